// File: doc/BRIEF.md
# Debug Register Access Guard

This block guards the register space of a memory-mapped debug component. It keeps a lock that blocks register writes until software writes an exact 32-bit unlock key to a key register. A status register reports the lock state.

It also holds a small claim tag. Software and an external debugger use the tag to agree on who owns the component. The tag has one write-one-to-set register and one write-one-to-clear register. Reading the set register returns the mask of implemented claim bits. Reading the clear register returns the current tag.

The host component keeps its own functional registers. The block only gives the host a per-write enable to gate them, and supplies read data for its own four offsets.

Top module: `dbg_access_guard`

## Requirements
- R1: After synchronous reset, the lock is engaged when the lock is present, the claim tag is 0, and rd_data is 0.
- R2: A write of exactly 0xC5ACCE55 to the key register (offset 0xFB0) releases the lock from the next cycle on.
- R3: A write of any other value to the key register, including values one bit away from the key, engages the lock.
- R4: While locked, claim set and clear writes and host writes are ignored and wr_allow stays low; the key register still accepts writes.
- R5: Reads are served whether locked or not. The status register (offset 0xFB4) returns bit 0 = lock present, bit 1 = locked, bit 2 = 0 (the key register is 32 bits wide), and 0 in all other bits.
- R6: With LOCK_PRESENT = 0, writes to the key register are ignored, the lock never engages, and status bits 0 and 1 read 0.
- R7: A write to the claim set register (offset 0xFA0) sets each claim bit whose write-data bit is 1 and leaves the claim bits written with 0 unchanged.
- R8: A write to the claim clear register (offset 0xFA4) clears each claim bit whose write-data bit is 1. A read of that register returns the current tag in bits [CLAIM_BITS-1:0].
- R9: A read of the claim set register returns the implemented-bit mask: ones in bits [CLAIM_BITS-1:0] (0xF for four bits).
- R10: rd_data is registered. It holds the addressed value in the cycle after bus_rd is high and 0 in the cycle after bus_rd is low. Reads of the key register and of offsets outside this block return 0.
- R11: wr_allow is high in the same cycle as bus_wr when the block is unlocked and the address is not the key register; otherwise it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DATA_W | Write data |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| rd_data | output | DATA_W | Registered read data for this block's offsets |
| wr_allow | output | 1 | Same-cycle write enable for the host's own registers |

## Verification
wr_allow is combinational and is due in the same cycle as the write strobe. The bench samples it shortly after driving the inputs, before the clock edge. rd_data is due one edge after bus_rd. A write to the key, set or clear register changes state at that same edge, so its effect appears in a read issued in the following cycle, not in a read issued together with the write. A behavioural model advances at each rising edge and is compared with both outputs every cycle, at the falling edge after it. Two instances, with and without a lock, are driven by the same bus.

// File: rtl/dag_pkg.sv
package dag_pkg;
  localparam logic [11:0] OFS_CLAIM_SET = 12'hFA0;
  localparam logic [11:0] OFS_CLAIM_CLR = 12'hFA4;
  localparam logic [11:0] OFS_LOCK_KEY  = 12'hFB0;
  localparam logic [11:0] OFS_LOCK_STAT = 12'hFB4;

  localparam int STAT_PRESENT_BIT = 0;
  localparam int STAT_LOCKED_BIT  = 1;
  localparam int STAT_TYPE_BIT    = 2;

  typedef struct packed {
    logic claim_set;
    logic claim_clr;
    logic lock_key;
    logic lock_stat;
  } dag_hit_t;
endpackage

// File: rtl/dag_decode.sv
module dag_decode
  import dag_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output dag_hit_t          hit
);
  always_comb begin
    hit.claim_set = (addr == ADDR_W'(OFS_CLAIM_SET));
    hit.claim_clr = (addr == ADDR_W'(OFS_CLAIM_CLR));
    hit.lock_key  = (addr == ADDR_W'(OFS_LOCK_KEY));
    hit.lock_stat = (addr == ADDR_W'(OFS_LOCK_STAT));
  end
endmodule

// File: rtl/dag_lock.sv
module dag_lock #(
  parameter int              DATA_W       = 32,
  parameter bit              LOCK_PRESENT = 1'b1,
  parameter logic [DATA_W-1:0] UNLOCK_KEY = 32'hC5ACCE55
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              key_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic              locked
);
  logic locked_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      locked_q <= LOCK_PRESENT;
    end else if (key_wr && LOCK_PRESENT) begin
      locked_q <= (wdata != UNLOCK_KEY);
    end
  end

  assign locked = locked_q;
endmodule

// File: rtl/dag_claim.sv
module dag_claim #(
  parameter int CLAIM_BITS = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  set_wr,
  input  logic                  clr_wr,
  input  logic [CLAIM_BITS-1:0] wbits,
  output logic [CLAIM_BITS-1:0] tag
);
  for (genvar g = 0; g < CLAIM_BITS; g++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        bit_q <= 1'b0;
      end else if (set_wr && wbits[g]) begin
        bit_q <= 1'b1;
      end else if (clr_wr && wbits[g]) begin
        bit_q <= 1'b0;
      end
    end
    assign tag[g] = bit_q;
  end
endmodule

// File: rtl/dag_rdport.sv
module dag_rdport
  import dag_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter int CLAIM_BITS   = 4,
  parameter bit LOCK_PRESENT = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  rd,
  input  dag_hit_t              hit,
  input  logic [CLAIM_BITS-1:0] tag,
  input  logic                  locked,
  output logic [DATA_W-1:0]     rd_data
);
  logic [DATA_W-1:0] rd_next;
  logic [DATA_W-1:0] rd_q;

  always_comb begin
    rd_next = '0;
    if (hit.claim_set) begin
      rd_next[CLAIM_BITS-1:0] = '1;
    end else if (hit.claim_clr) begin
      rd_next[CLAIM_BITS-1:0] = tag;
    end else if (hit.lock_stat) begin
      rd_next[STAT_PRESENT_BIT] = LOCK_PRESENT;
      rd_next[STAT_LOCKED_BIT]  = locked;
      rd_next[STAT_TYPE_BIT]    = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= '0;
    end else if (rd) begin
      rd_q <= rd_next;
    end else begin
      rd_q <= '0;
    end
  end

  assign rd_data = rd_q;
endmodule

// File: rtl/dbg_access_guard.sv
module dbg_access_guard
  import dag_pkg::*;
#(
  parameter int                ADDR_W       = 12,
  parameter int                DATA_W       = 32,
  parameter int                CLAIM_BITS   = 4,
  parameter bit                LOCK_PRESENT = 1'b1,
  parameter logic [DATA_W-1:0] UNLOCK_KEY   = 32'hC5ACCE55
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] rd_data,
  output logic              wr_allow
);
  dag_hit_t              hit;
  logic                  locked_q;
  logic [CLAIM_BITS-1:0] claim_q;
  logic                  key_wr;
  logic                  ctl_wr;

  dag_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr (bus_addr),
    .hit  (hit)
  );

  assign key_wr   = bus_wr && hit.lock_key;
  assign ctl_wr   = bus_wr && !locked_q && !hit.lock_key;
  assign wr_allow = ctl_wr;

  dag_lock #(
    .DATA_W       (DATA_W),
    .LOCK_PRESENT (LOCK_PRESENT),
    .UNLOCK_KEY   (UNLOCK_KEY)
  ) u_lock (
    .clk    (clk),
    .rst    (rst),
    .key_wr (key_wr),
    .wdata  (bus_wdata),
    .locked (locked_q)
  );

  dag_claim #(.CLAIM_BITS(CLAIM_BITS)) u_claim (
    .clk    (clk),
    .rst    (rst),
    .set_wr (ctl_wr && hit.claim_set),
    .clr_wr (ctl_wr && hit.claim_clr),
    .wbits  (bus_wdata[CLAIM_BITS-1:0]),
    .tag    (claim_q)
  );

  dag_rdport #(
    .DATA_W       (DATA_W),
    .CLAIM_BITS   (CLAIM_BITS),
    .LOCK_PRESENT (LOCK_PRESENT)
  ) u_rdport (
    .clk     (clk),
    .rst     (rst),
    .rd      (bus_rd),
    .hit     (hit),
    .tag     (claim_q),
    .locked  (locked_q),
    .rd_data (rd_data)
  );
endmodule

// File: rtl/dag_checks.sv
module dag_checks #(
  parameter int                DATA_W       = 32,
  parameter int                CLAIM_BITS   = 4,
  parameter bit                LOCK_PRESENT = 1'b1,
  parameter logic [DATA_W-1:0] UNLOCK_KEY   = 32'hC5ACCE55
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  key_wr,
  input logic [DATA_W-1:0]     wdata,
  input logic                  bus_rd,
  input logic                  wr_allow,
  input logic                  locked,
  input logic [CLAIM_BITS-1:0] claim,
  input logic [DATA_W-1:0]     rd_data
);
  p_key_unlock_r2: assert property (@(posedge clk) disable iff (rst)
    (LOCK_PRESENT && key_wr && wdata == UNLOCK_KEY) |=> !locked);

  p_bad_key_relock_r3: assert property (@(posedge clk) disable iff (rst)
    (LOCK_PRESENT && key_wr && wdata != UNLOCK_KEY) |=> locked);

  p_locked_no_allow_r4: assert property (@(posedge clk) disable iff (rst)
    locked |-> !wr_allow);

  p_locked_claim_frozen_r4: assert property (@(posedge clk) disable iff (rst)
    locked |=> $stable(claim));

  p_idle_read_zero_r10: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> rd_data == '0);
endmodule

bind dbg_access_guard dag_checks #(
  .DATA_W       (DATA_W),
  .CLAIM_BITS   (CLAIM_BITS),
  .LOCK_PRESENT (LOCK_PRESENT),
  .UNLOCK_KEY   (UNLOCK_KEY)
) u_dag_checks (
  .clk      (clk),
  .rst      (rst),
  .key_wr   (key_wr),
  .wdata    (bus_wdata),
  .bus_rd   (bus_rd),
  .wr_allow (wr_allow),
  .locked   (locked_q),
  .claim    (claim_q),
  .rd_data  (rd_data)
);

// File: tb/test_dbg_access_guard.sv
module test_dbg_access_guard;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] KEY = 32'hC5ACCE55;
  localparam logic [11:0] A_CSET = 12'hFA0;
  localparam logic [11:0] A_CCLR = 12'hFA4;
  localparam logic [11:0] A_KEY  = 12'hFB0;
  localparam logic [11:0] A_STAT = 12'hFB4;
  localparam logic [11:0] A_HOST = 12'h010;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] rd_a, rd_b;
  logic        wa_a, wa_b;

  int total = 0;
  int bad = 0;

  bit       m_locked  [2];
  bit [3:0] m_tag     [2];
  bit       m_present [2] = '{1'b1, 1'b0};

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_access_guard i_dbg_access_guard (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .rd_data(rd_a), .wr_allow(wa_a)
  );

  dbg_access_guard #(.LOCK_PRESENT(1'b0)) i_dbg_access_guard_nolock (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .rd_data(rd_b), .wr_allow(wa_b)
  );

  task automatic check(input string req, input string what, input int inst,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s inst=%0d act=%h exp=%h", req, what, inst, act, exp);
    end
  endtask

  function automatic logic [31:0] model_read(input int i, input logic [11:0] a);
    logic [31:0] v = '0;
    if (a == A_CSET) v[3:0] = 4'hF;
    else if (a == A_CCLR) v[3:0] = m_tag[i];
    else if (a == A_STAT) begin
      v[0] = m_present[i];
      v[1] = m_locked[i];
    end
    return v;
  endfunction

  // Called at a falling edge; returns at the next falling edge.
  task automatic step(input logic [11:0] a, input bit w, input logic [31:0] d,
                      input bit r, input string req);
    logic [31:0] exp_rd [2];
    bus_addr = a; bus_wr = w; bus_wdata = d; bus_rd = r;
    #1;
    for (int i = 0; i < 2; i++) begin
      bit exp_wa = w && !m_locked[i] && (a != A_KEY);
      check(req, "wr_allow", i, {31'b0, (i == 0) ? wa_a : wa_b}, {31'b0, exp_wa});
    end
    @(posedge clk);
    for (int i = 0; i < 2; i++) begin
      exp_rd[i] = r ? model_read(i, a) : 32'h0;
      if (w) begin
        if (a == A_KEY) begin
          if (m_present[i]) m_locked[i] = (d != KEY);
        end else if (!m_locked[i]) begin
          if (a == A_CSET) m_tag[i] = m_tag[i] | d[3:0];
          if (a == A_CCLR) m_tag[i] = m_tag[i] & ~d[3:0];
        end
      end
    end
    @(negedge clk);
    check(req, "rd_data", 0, rd_a, exp_rd[0]);
    check(req, "rd_data", 1, rd_b, exp_rd[1]);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog all act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 2; i++) begin
      m_locked[i] = m_present[i];
      m_tag[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    step(A_HOST, 0, 0, 0, "R1 idle after reset");
    step(A_STAT, 0, 0, 1, "R1 R5 status after reset");
    step(A_CCLR, 0, 0, 1, "R1 tag after reset");
    step(A_CSET, 1, 32'hF, 0, "R4 claim set while locked");
    step(A_CCLR, 0, 0, 1, "R4 tag unchanged while locked");
    step(A_HOST, 1, 32'h1234, 0, "R4 R11 host write while locked");
    step(A_KEY, 1, 32'hC5ACCE54, 0, "R3 near-miss key");
    step(A_STAT, 0, 0, 1, "R3 R5 still locked");
    step(A_KEY, 1, KEY, 1, "R2 R10 key write with key read");
    step(A_STAT, 0, 0, 1, "R2 R6 status after key");
    step(A_HOST, 1, 32'h55, 0, "R11 host write unlocked");
    step(A_CSET, 1, 32'h5, 0, "R7 set 0101");
    step(A_CCLR, 0, 0, 1, "R7 R8 read tag");
    step(A_CSET, 1, 32'h2, 0, "R7 set 0010 keeps others");
    step(A_CCLR, 0, 0, 1, "R7 read tag 0111");
    step(A_CSET, 0, 0, 1, "R9 implemented mask");
    step(A_CCLR, 1, 32'h4, 0, "R8 clear bit 2");
    step(A_CCLR, 1, 32'h0, 1, "R8 clear zero no effect");
    step(A_CCLR, 0, 0, 1, "R8 read tag 0011");
    step(A_KEY, 0, 0, 1, "R10 key reads zero");
    step(A_HOST, 0, 0, 1, "R10 foreign read zero");
    step(A_KEY, 1, 32'hFFFFFFFF, 0, "R3 relock");
    step(A_CCLR, 1, 32'hF, 0, "R4 clear while locked");
    step(A_CCLR, 0, 0, 1, "R4 R5 read tag while locked");
    step(A_STAT, 0, 0, 1, "R5 R6 status relocked");
    step(A_KEY, 1, KEY, 0, "R2 unlock again");
    step(A_CCLR, 1, 32'hF, 0, "R8 clear all");
    step(A_CCLR, 0, 0, 1, "R8 tag zero");
    step(A_HOST, 0, 0, 0, "R10 idle");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule